// File: doc/BRIEF.md
# Paged External Program Fetch Sequencer

This block produces the bus waveforms for instruction fetches from an external program memory when a page-oriented fetch mode is active. The core hands over a 16-bit fetch address with a request pulse. The block drives one 8-bit multiplexed address port, an address-latch strobe and a program-read enable, and reads the byte back from a separate 8-bit data-only port. It returns the byte with a one-clock done pulse.

The block keeps the high address byte of the last page it latched. A fetch inside that 256-byte page runs a short 4-clock cycle that only presents the low address byte. A fetch in a different page runs an 8-clock cycle: the high byte is first driven and latched externally with the strobe, and then the short waveform follows. The core can flag a request as following a two-cycle single-byte instruction. The block then runs one dummy slot at that address before the real fetch. The mode is set up through a small configuration write port, and it can be entered only while the core executes from internal code memory.

Top module: `pgf_fetch_ctrl`

## Requirements
- R1: While reset is held and right after it, `ale`, `psen` and `done` are low, and the page mode is off.
- R2: The page mode turns on only through a configuration write with `cfg_en`=1 and `cfg_sel`=2'b10, made when the stored select field already holds 2'b10 from an earlier write. A write with `cfg_en`=1 and any other select value leaves the mode off, so every fetch stays 8 clocks long.
- R3: A configuration write that would turn the mode on has no effect while `exec_internal` is low.
- R4: After reset, and after every write that turns the mode on, the first fetch runs as a page miss (8 clocks).
- R5: A page-hit fetch ends with `done` in its 4th clock after acceptance. `ale` stays low and `addr_port` carries address bits [7:0] in all 4 clocks.
- R6: A page-miss fetch lasts 8 clocks. In clocks 1 to 4, `addr_port` carries address bits [15:8] and `ale` is high in clocks 1 and 2 and low in clocks 3 and 4. Clocks 5 to 8 repeat the hit waveform.
- R7: `psen` is high for exactly clocks 2 and 3 of each 4-clock fetch phase. `data_in` is captured at the clock edge that ends clock 3, and it is presented on `rdata` with `done` in clock 4.
- R8: A fetch whose address bits [15:8] differ from the latched high byte is a page miss, and the new high byte becomes the latched one.
- R9: A request with `req_stall`=1 first runs one dummy slot at its address, with no `done`. The slot is 4 or 8 clocks long by the page rule. The real fetch follows at once as a 4-clock hit, so the total is 8 clocks on a hit page and 12 clocks on a miss page.
- R10: A request is accepted only while the block is idle or in the clock where `done` is high. A request raised during the other clocks of a busy cycle is ignored. A request accepted in the done clock starts its cycle in the next clock.
- R11: While the mode is off, every fetch runs the 8-clock latch waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Page-select field written by the strobe |
| cfg_en | input | 1 | Page-enable bit written by the strobe |
| exec_internal | input | 1 | High while the core executes from internal code memory |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 16 | Fetch address |
| req_stall | input | 1 | Insert one dummy slot before this fetch |
| done | output | 1 | One-clock pulse: fetched byte valid on `rdata` |
| rdata | output | 8 | Fetched byte |
| addr_port | output | 8 | Multiplexed high/low address byte |
| data_in | input | 8 | External program data |
| ale | output | 1 | Address-latch strobe, active high |
| psen | output | 1 | Program-read enable, active high |

## Verification
The bench goes after the page boundary. A design that compares the wrong bits, or never updates its latched byte, runs short cycles across pages or long cycles inside one page, and this shows up as a wrong count of clocks to `done`. It checks the enable sequence: enabling with the wrong select value, enabling while `exec_internal` is low, and re-enabling must each give the right cycle lengths. A sloppy mode register enters page mode too early, or keeps a stale page valid so the first fetch comes out short. The stall slot is run on both a hit page and a miss page. A design that reports `done` for the dummy, or skips it, returns early. A back-to-back request held in the done clock, and a stray request in mid-cycle, expose a handshake that drops the first or accepts the second.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    // Position inside a fetch cycle. Values 0..3 form the latch phase of a
    // miss cycle, 4..7 the fetch phase shared by hits and misses.
    typedef logic [2:0] phase_t;

    localparam phase_t PH_LATCH_FIRST = 3'd0;
    localparam phase_t PH_LATCH_LAST  = 3'd1;
    localparam phase_t PH_FETCH_FIRST = 3'd4;
    localparam phase_t PH_READ_A      = 3'd5;
    localparam phase_t PH_READ_B      = 3'd6;
    localparam phase_t PH_LAST        = 3'd7;

    function automatic phase_t start_phase(input logic page_hit);
        return page_hit ? PH_FETCH_FIRST : PH_LATCH_FIRST;
    endfunction

    function automatic logic in_latch(input phase_t ph);
        return !ph[2];
    endfunction

endpackage

// File: rtl/pgf_mode_reg.sv
module pgf_mode_reg #(
    parameter int unsigned SEL_W    = 2,
    parameter logic [1:0]  SEL_CODE = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  logic             exec_internal,
    output logic             mode_on,
    output logic             arm
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             on;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        arm = cfg_we && cfg_en && exec_internal &&
              (m_q.sel == SEL_W'(SEL_CODE)) && (cfg_sel == SEL_W'(SEL_CODE));
        if (cfg_we) begin
            m_d.sel = cfg_sel;
            if (!cfg_en || (cfg_sel != SEL_W'(SEL_CODE))) begin
                m_d.on = 1'b0;
            end else if (arm) begin
                m_d.on = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mode_on = m_q.on;
endmodule

// File: rtl/pgf_page_tag.sv
module pgf_page_tag #(
    parameter int unsigned HI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            clear,
    input  logic            load,
    input  logic [HI_W-1:0] probe_hi,
    output logic            hit
);
    typedef struct packed {
        logic            valid;
        logic [HI_W-1:0] tag;
    } tag_t;

    tag_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        hit = enable && t_q.valid && (t_q.tag == probe_hi);
        if (clear) begin
            t_d.valid = 1'b0;
        end else if (load) begin
            t_d.valid = 1'b1;
            t_d.tag   = probe_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/pgf_bus_decode.sv
module pgf_bus_decode
    import pgf_pkg::*;
#(
    parameter int unsigned HI_W   = 8,
    parameter int unsigned LO_W   = 8,
    parameter int unsigned PORT_W = 8
) (
    input  logic              busy,
    input  phase_t            ph,
    input  logic [HI_W-1:0]   hi,
    input  logic [LO_W-1:0]   lo,
    output logic [PORT_W-1:0] addr_port,
    output logic              ale,
    output logic              psen
);
    always_comb begin
        addr_port = PORT_W'(lo);
        ale       = 1'b0;
        psen      = 1'b0;
        if (busy) begin
            if (in_latch(ph)) begin
                addr_port = PORT_W'(hi);
            end
            ale  = (ph == PH_LATCH_FIRST) || (ph == PH_LATCH_LAST);
            psen = (ph == PH_READ_A) || (ph == PH_READ_B);
        end
    end
endmodule

// File: rtl/pgf_fetch_ctrl.sv
module pgf_fetch_ctrl
    import pgf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_en,
    input  logic              exec_internal,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_stall,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGE_W-1:0] addr_port,
    input  logic [DATA_W-1:0] data_in,
    output logic              ale,
    output logic              psen
);
    localparam int unsigned HI_W = ADDR_W - PAGE_W;

    typedef struct packed {
        logic              busy;
        logic              dummy;
        phase_t            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic            mode_on;
    logic            arm;
    logic            tag_hit;
    logic            tag_load;
    logic            done_w;
    logic            accept;
    logic [HI_W-1:0] probe_hi;

    pgf_mode_reg #(.SEL_W(SEL_W)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_en        (cfg_en),
        .exec_internal (exec_internal),
        .mode_on       (mode_on),
        .arm           (arm)
    );

    pgf_page_tag #(.HI_W(HI_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (mode_on),
        .clear    (!mode_on || arm),
        .load     (tag_load),
        .probe_hi (probe_hi),
        .hit      (tag_hit)
    );

    always_comb begin
        s_d      = s_q;
        tag_load = 1'b0;
        done_w   = s_q.busy && !s_q.dummy && (s_q.ph == PH_LAST);
        accept   = req_valid && (!s_q.busy || done_w);
        probe_hi = accept ? req_addr[ADDR_W-1:PAGE_W] : s_q.addr[ADDR_W-1:PAGE_W];

        if (s_q.busy) begin
            if ((s_q.ph == PH_READ_B) && !s_q.dummy) begin
                s_d.rdata = data_in;
            end
            if (s_q.ph == PH_LAST) begin
                if (s_q.dummy) begin
                    s_d.dummy = 1'b0;
                    s_d.ph    = start_phase(tag_hit);
                    tag_load  = 1'b1;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.ph = s_q.ph + 3'd1;
            end
        end

        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.dummy = req_stall;
            s_d.addr  = req_addr;
            s_d.ph    = start_phase(tag_hit);
            tag_load  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    pgf_bus_decode #(.HI_W(HI_W), .LO_W(PAGE_W), .PORT_W(PAGE_W)) u_bus (
        .busy      (s_q.busy),
        .ph        (s_q.ph),
        .hi        (s_q.addr[ADDR_W-1:PAGE_W]),
        .lo        (s_q.addr[PAGE_W-1:0]),
        .addr_port (addr_port),
        .ale       (ale),
        .psen      (psen)
    );

    assign done  = done_w;
    assign rdata = s_q.rdata;
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic psen,
    input logic done
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_quiet_reset_r1: assert (!ale && !psen && !done)
                else $error("bus active during reset");
        end
    end

    p_ale_two_clocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);

    p_ale_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !psen);

    p_psen_two_clocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen) |=> psen ##1 !psen);

    p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(psen) && !psen && !ale));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind pgf_fetch_ctrl pgf_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .psen  (psen),
    .done  (done)
);

// File: tb/pgf_fetch_ctrl_tb.sv
module pgf_fetch_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic        cfg_en = 1'b0;
    logic        exec_internal = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_stall = 1'b0;
    logic        done;
    logic [7:0]  rdata;
    logic [7:0]  addr_port;
    logic [7:0]  data_in;
    logic        ale;
    logic        psen;
    logic [7:0]  cur_exp = 8'h00;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign data_in = psen ? cur_exp : 8'hEE;

    pgf_fetch_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_en        (cfg_en),
        .exec_internal (exec_internal),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_stall     (req_stall),
        .done          (done),
        .rdata         (rdata),
        .addr_port     (addr_port),
        .data_in       (data_in),
        .ale           (ale),
        .psen          (psen)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic write_mode(input logic [1:0] sel, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_en = en;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // Runs one request and checks length, data and waveform.
    task automatic fetch(input logic [15:0] a, input logic stall, input int exp_len,
                         input bit long_first, input string tag,
                         input bit pre_issued = 1'b0, input bit chain = 1'b0,
                         input logic [15:0] next_a = 16'h0);
        logic       ale_v  [1:20];
        logic       psen_v [1:20];
        logic [7:0] port_v [1:20];
        int         len = 0;
        int         ale_cnt = 0;
        logic [7:0] got = 8'h00;
        bit         ok;
        if (!pre_issued) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = a; req_stall = stall;
        end
        @(posedge clk); #1;
        req_valid = 1'b0; req_stall = 1'b0;
        cur_exp = pat(a);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            ale_v[k] = ale; psen_v[k] = psen; port_v[k] = addr_port;
            if (ale) ale_cnt++;
            if (done) begin
                len = k; got = rdata;
                if (chain) begin
                    req_valid = 1'b1; req_addr = next_a; req_stall = 1'b0;
                end
                break;
            end
        end
        chk(len == exp_len, {tag, " cycle length"}, len, exp_len);
        chk(got == pat(a), {tag, " R7 data"}, got, pat(a));
        chk(ale_cnt == (long_first ? 2 : 0), {tag, " strobe count"}, ale_cnt, long_first ? 2 : 0);
        if (len >= 4) begin
            ok = 1'b1;
            for (int j = 0; j < 4; j++) begin
                if (port_v[len-3+j] != a[7:0]) ok = 1'b0;
                if (psen_v[len-3+j] != ((j == 1) || (j == 2))) ok = 1'b0;
                if (ale_v[len-3+j]) ok = 1'b0;
            end
            chk(ok, {tag, " R5 R7 fetch-phase waveform"}, ok, 1);
        end
        if (long_first && len >= 8) begin
            ok = 1'b1;
            for (int j = 1; j <= 4; j++) begin
                if (port_v[j] != a[15:8]) ok = 1'b0;
                if (ale_v[j] != (j <= 2)) ok = 1'b0;
                if (psen_v[j]) ok = 1'b0;
            end
            chk(ok, {tag, " R6 latch-phase waveform"}, ok, 1);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!ale && !psen && !done, "R1 outputs in reset", {ale, psen, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ale && !psen && !done, "R1 outputs after reset", {ale, psen, done}, 0);
    endtask

    task automatic t_mode_ignored();
        exec_internal = 1'b0;
        write_mode(2'b10, 1'b0);
        write_mode(2'b10, 1'b1);
        fetch(16'h1234, 1'b0, 8, 1'b1, "R3 R11 first");
        fetch(16'h1235, 1'b0, 8, 1'b1, "R3 R11 same page");
        exec_internal = 1'b1;
    endtask

    task automatic t_wrong_sel();
        write_mode(2'b01, 1'b0);
        write_mode(2'b01, 1'b1);
        fetch(16'h2200, 1'b0, 8, 1'b1, "R2 wrong select a");
        fetch(16'h2201, 1'b0, 8, 1'b1, "R2 wrong select b");
    endtask

    task automatic t_enter();
        write_mode(2'b10, 1'b0);
        write_mode(2'b10, 1'b1);
        fetch(16'h4010, 1'b0, 8, 1'b1, "R4 R2 first after enable");
        fetch(16'h4011, 1'b0, 4, 1'b0, "R5 hit");
        fetch(16'h40FF, 1'b0, 4, 1'b0, "R5 hit page end");
    endtask

    task automatic t_cross();
        fetch(16'h4100, 1'b0, 8, 1'b1, "R8 R6 boundary crossed");
        fetch(16'h4101, 1'b0, 4, 1'b0, "R8 new page kept");
        fetch(16'h4001, 1'b0, 8, 1'b1, "R8 back to old page");
    endtask

    task automatic t_stall();
        fetch(16'h4002, 1'b1, 8, 1'b0, "R9 dummy on hit page");
        fetch(16'h5000, 1'b1, 12, 1'b1, "R9 dummy on miss page");
    endtask

    task automatic t_back_to_back();
        fetch(16'h5001, 1'b0, 4, 1'b0, "R10 first", 1'b0, 1'b1, 16'h5002);
        fetch(16'h5002, 1'b0, 4, 1'b0, "R10 taken in done clock", 1'b1);
    endtask

    task automatic t_busy_ignore();
        int len = 0;
        int extra = 0;
        logic [7:0] got = 8'h00;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h5003; req_stall = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b0;
        cur_exp = pat(16'h5003);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h6000;
        @(posedge clk); #1;
        req_valid = 1'b0;
        for (int k = 2; k <= 12; k++) begin
            @(negedge clk);
            if (done) begin
                if (len == 0) begin len = k; got = rdata; end
                else extra++;
            end
            if (ale) extra++;
        end
        chk(len == 4, "R10 busy fetch length", len, 4);
        chk(got == pat(16'h5003), "R10 busy fetch data", got, pat(16'h5003));
        chk(extra == 0, "R10 mid-cycle request ignored", extra, 0);
    endtask

    task automatic t_mode_off();
        write_mode(2'b10, 1'b0);
        fetch(16'h5004, 1'b0, 8, 1'b1, "R11 mode off same page");
        write_mode(2'b10, 1'b1);
        fetch(16'h5005, 1'b0, 8, 1'b1, "R4 re-enable first");
        fetch(16'h5006, 1'b0, 4, 1'b0, "R5 re-enable hit");
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        t_reset();
        t_mode_ignored();
        t_wrong_sel();
        t_enter();
        t_cross();
        t_stall();
        t_back_to_back();
        t_busy_ignore();
        t_mode_off();
        repeat (3) @(negedge clk);
        report();
    end
endmodule